// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Halfword Register Sequencing

This block keeps a time-of-day value for a precision time protocol node: a 32-bit seconds count and a 30-bit nanoseconds count that wraps at one billion. It runs from a fixed-period reference clock. Each running cycle adds a nominal 8 ns. A fractional rate accumulator trims that step up or down by one nanosecond at a programmable average rate.

Software reaches the counter through a 16-bit register port with four addresses. Address 0 is the command register. Address 1 is a shared time data register. Address 2 is the high trim register and address 3 is the low trim register.

Every time value moves through the data register as four halfwords in a fixed order. A command then acts on the staged value or on the live time. It can load the staged value as an absolute time, add it to the live time as a signed step, or capture the live time so it can be read back as four halfwords.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset, `sec_o` and `ns_o` are zero, `running_o` is 0, and a read of address 1 returns 0.
- R2: Writes to address 1 fill a four-slot staging area in this order: ns[15:0], ns[31:16], sec[15:0], sec[31:16]. A command write with bit 2 set replaces the live time with the staged value one cycle later. A staged nanosecond value of 1,000,000,000 or more is loaded as 0.
- R3: A command write with bit 3 set, and bit 2 clear, adds the staged seconds to the live seconds. It also adds the staged 32-bit nanosecond field, taken as two's complement, to the live nanoseconds, so a negative field subtracts. The nanosecond result is brought back into range with a carry into seconds or a borrow from seconds. A nanosecond field whose magnitude is 1,000,000,000 or more contributes 0.
- R4: A command write with bit 4 set captures the live time at that clock edge. The following four reads of address 1 return ns[15:0], {2'b00, ns[29:16]}, sec[15:0] and sec[31:16], in that order.
- R5: Any write to address 0 returns the halfword pointer to slot 0, whatever value is written. A partial write or read sequence therefore does not shift later accesses.
- R6: Command bit 0 starts the counter and bit 1 stops it, with bit 0 taking priority. While stopped, the time holds except for load and step.
- R7: While running, the nanoseconds advance by 8 each cycle, plus or minus the trim of R8. On reaching 1,000,000,000 they wrap and the seconds increment.
- R8: The trim word is {address2[9:0], address3[15:0]}. Each running cycle, this word is added to a 32-bit accumulator. On a carry out, the step becomes 9 if address2 bit 15 is 1, or 7 if it is 0.
- R9: `ns_o` never reaches 1,000,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; advances the pointer on address 1 |
| reg_addr | input | 2 | 0 command, 1 time data, 2 trim high, 3 trim low |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid combinationally from address and pointer |
| sec_o | output | 32 | Live seconds |
| ns_o | output | 30 | Live nanoseconds |
| running_o | output | 1 | Counter is running |

## Verification
The bench goes after the nanosecond rollover at one billion. A design that compared against the wrong bound would show a value out of range or miss the seconds carry.

It also drives negative steps that need a borrow. Sign handling done in unsigned arithmetic would leave the time about four seconds off.

It issues command writes in the middle of a halfword sequence. If the pointer were not cleared, the next value would be loaded with its words rotated.

Finally, it runs the trim accumulator in both directions at large rates. If the carry were ignored or applied in the wrong direction, the nanoseconds would drift away from the reference model within a few dozen cycles.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam logic [31:0] NS_PER_SEC = 32'd1000000000;

    typedef enum logic [1:0] {
        ADDR_CMD     = 2'd0,
        ADDR_TDATA   = 2'd1,
        ADDR_RATE_HI = 2'd2,
        ADDR_RATE_LO = 2'd3
    } reg_addr_e;

    localparam int CMD_RUN   = 0;
    localparam int CMD_HALT  = 1;
    localparam int CMD_LOAD  = 2;
    localparam int CMD_STEP  = 3;
    localparam int CMD_LATCH = 4;
    localparam int RATE_DIR  = 15;

    typedef struct packed {
        logic [31:0] sec;
        logic [29:0] ns;
    } tod_t;

endpackage

// File: rtl/ptp_tod_seq.sv
module ptp_tod_seq
    import ptp_tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        latch_cmd,
    input  logic        data_wr,
    input  logic        data_rd,
    input  logic [15:0] wdata,
    input  tod_t        live,
    output logic [31:0] staged_sec,
    output logic [31:0] staged_ns,
    output logic [15:0] rdata
);

    localparam int SLOTS = 4;
    localparam int PTR_W = $clog2(SLOTS);

    typedef struct packed {
        logic [PTR_W-1:0]       ptr;
        logic [SLOTS-1:0][15:0] stage;
        logic [SLOTS-1:0][15:0] shadow;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (cmd_wr) begin
            d.ptr = '0;
        end
        if (latch_cmd) begin
            d.shadow[0] = live.ns[15:0];
            d.shadow[1] = {2'b00, live.ns[29:16]};
            d.shadow[2] = live.sec[15:0];
            d.shadow[3] = live.sec[31:16];
        end
        if (data_wr) begin
            d.stage[q.ptr] = wdata;
            d.ptr          = q.ptr + 1'b1;
        end else if (data_rd) begin
            d.ptr = q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign staged_ns  = {q.stage[1], q.stage[0]};
    assign staged_sec = {q.stage[3], q.stage[2]};
    assign rdata      = q.shadow[q.ptr];

endmodule

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate
    import ptp_tod_pkg::*;
#(
    parameter int NOMINAL_INC  = 8,
    parameter int RATE_HI_BITS = 10,
    parameter int ACC_W        = 32,
    parameter int INC_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hi_wr,
    input  logic             lo_wr,
    input  logic [15:0]      wdata,
    output logic [INC_W-1:0] inc
);

    localparam int RATE_W = RATE_HI_BITS + 16;

    typedef struct packed {
        logic                    dir;
        logic [RATE_HI_BITS-1:0] hi;
        logic [15:0]             lo;
        logic [ACC_W-1:0]        acc;
    } rate_t;

    rate_t q, d;
    logic [ACC_W:0] sum;
    logic           carry;

    always_comb begin
        d     = q;
        sum   = {1'b0, q.acc} + (ACC_W+1)'({q.hi, q.lo});
        carry = sum[ACC_W];
        if (run) d.acc = sum[ACC_W-1:0];
        if (hi_wr) begin
            d.dir = wdata[RATE_DIR];
            d.hi  = wdata[RATE_HI_BITS-1:0];
        end
        if (lo_wr) d.lo = wdata;
        if (!carry)     inc = INC_W'(NOMINAL_INC);
        else if (q.dir) inc = INC_W'(NOMINAL_INC + 1);
        else            inc = INC_W'(NOMINAL_INC - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    initial begin
        if (RATE_W > ACC_W) $error("trim word wider than accumulator");
    end

endmodule

// File: rtl/ptp_tod_count.sv
module ptp_tod_count
    import ptp_tod_pkg::*;
#(
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             do_load,
    input  logic             do_step,
    input  logic [31:0]      staged_sec,
    input  logic [31:0]      staged_ns,
    input  logic [INC_W-1:0] inc,
    output tod_t             tod
);

    tod_t q, d;
    logic [31:0]        adv;
    logic signed [33:0] step_eff;
    logic signed [33:0] step_sum;
    logic signed [33:0] lim;
    logic               step_ok;

    always_comb begin
        d        = q;
        lim      = $signed({2'b00, NS_PER_SEC});
        adv      = {2'b00, q.ns} + 32'(inc);
        step_eff = $signed({{2{staged_ns[31]}}, staged_ns});
        step_ok  = (step_eff < lim) && (step_eff > -lim);
        if (!step_ok) step_eff = '0;
        step_sum = $signed({4'b0000, q.ns}) + step_eff;

        if (do_load) begin
            d.sec = staged_sec;
            d.ns  = (staged_ns >= NS_PER_SEC) ? '0 : staged_ns[29:0];
        end else if (do_step) begin
            if (step_sum[33]) begin
                d.ns  = 30'(step_sum + lim);
                d.sec = q.sec + staged_sec - 32'd1;
            end else if (step_sum >= lim) begin
                d.ns  = 30'(step_sum - lim);
                d.sec = q.sec + staged_sec + 32'd1;
            end else begin
                d.ns  = 30'(step_sum);
                d.sec = q.sec + staged_sec;
            end
        end else if (run) begin
            if (adv >= NS_PER_SEC) begin
                d.ns  = 30'(adv - NS_PER_SEC);
                d.sec = q.sec + 32'd1;
            end else begin
                d.ns = adv[29:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tod = q;

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int NOMINAL_INC  = 8,
    parameter int RATE_HI_BITS = 10,
    parameter int ACC_W        = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [31:0] sec_o,
    output logic [29:0] ns_o,
    output logic        running_o
);

    localparam int INC_W = $clog2(NOMINAL_INC + 2);

    logic             cmd_wr;
    logic             run_d, run_q;
    logic [31:0]      staged_sec, staged_ns;
    logic [15:0]      seq_rdata;
    logic [INC_W-1:0] inc;
    tod_t             tod;

    always_comb begin
        cmd_wr = reg_wr && (reg_addr == ADDR_CMD);
        run_d  = run_q;
        if (cmd_wr && reg_wdata[CMD_RUN])       run_d = 1'b1;
        else if (cmd_wr && reg_wdata[CMD_HALT]) run_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    ptp_tod_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .latch_cmd (cmd_wr && reg_wdata[CMD_LATCH]),
        .data_wr   (reg_wr && (reg_addr == ADDR_TDATA)),
        .data_rd   (reg_rd && !reg_wr && (reg_addr == ADDR_TDATA)),
        .wdata     (reg_wdata),
        .live      (tod),
        .staged_sec(staged_sec),
        .staged_ns (staged_ns),
        .rdata     (seq_rdata)
    );

    ptp_tod_rate #(
        .NOMINAL_INC (NOMINAL_INC),
        .RATE_HI_BITS(RATE_HI_BITS),
        .ACC_W       (ACC_W),
        .INC_W       (INC_W)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .hi_wr (reg_wr && (reg_addr == ADDR_RATE_HI)),
        .lo_wr (reg_wr && (reg_addr == ADDR_RATE_LO)),
        .wdata (reg_wdata),
        .inc   (inc)
    );

    ptp_tod_count #(
        .INC_W(INC_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .do_load   (cmd_wr && reg_wdata[CMD_LOAD]),
        .do_step   (cmd_wr && reg_wdata[CMD_STEP]),
        .staged_sec(staged_sec),
        .staged_ns (staged_ns),
        .inc       (inc),
        .tod       (tod)
    );

    assign reg_rdata = (reg_addr == ADDR_TDATA) ? seq_rdata : 16'h0000;
    assign sec_o     = tod.sec;
    assign ns_o      = tod.ns;
    assign running_o = run_q;

endmodule

// File: rtl/ptp_tod_clock_chk.sv
module ptp_tod_clock_chk #(
    parameter int NOMINAL_INC = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic [31:0] sec_o,
    input logic [29:0] ns_o,
    input logic        running_o
);

    logic cmd_w;
    assign cmd_w = reg_wr && (reg_addr == 2'd0);

    assert_ns_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ns_o < 30'd1000000000);

    assert_halted_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !cmd_w) |=> ($stable(sec_o) && $stable(ns_o)));

    assert_start_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && reg_wdata[0]) |=> running_o);

    assert_halt_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && !reg_wdata[0] && reg_wdata[1]) |=> !running_o);

    assert_advance_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !cmd_w && ns_o < 30'd999999000) |=>
        (ns_o == $past(ns_o) + 30'(NOMINAL_INC) ||
         ns_o == $past(ns_o) + 30'(NOMINAL_INC - 1) ||
         ns_o == $past(ns_o) + 30'(NOMINAL_INC + 1)));

    assert_wrap_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !cmd_w && ns_o >= 30'd999999000) |=>
        (ns_o < 30'd1000 ? sec_o == $past(sec_o) + 32'd1 : sec_o == $past(sec_o)));

endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(.NOMINAL_INC(NOMINAL_INC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sec_o     (sec_o),
    .ns_o      (ns_o),
    .running_o (running_o)
);

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [31:0] sec_o;
    logic [29:0] ns_o;
    logic        running_o;

    int total = 0;
    int bad = 0;

    logic [31:0] m_sec;
    logic [29:0] m_ns;
    logic [31:0] m_acc;
    logic        m_run;
    logic        m_dir;
    logic [9:0]  m_hi;
    logic [15:0] m_lo;
    logic [1:0]  m_ptr;
    logic [15:0] m_stage [4];
    logic [15:0] m_shadow [4];

    always #10 clk = ~clk;

    ptp_tod_clock u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sec_o     (sec_o),
        .ns_o      (ns_o),
        .running_o (running_o)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_time(string tag);
        check({tag, " sec"}, 64'(sec_o), 64'(m_sec));
        check({tag, " ns"}, 64'(ns_o), 64'(m_ns));
        check({tag, " run"}, 64'(running_o), 64'(m_run));
    endtask

    // model of one clock edge from the requirements
    task automatic tick();
        logic        cw;
        logic [15:0] cmd;
        logic [32:0] sum;
        int          inc;
        logic [31:0] n_sec;
        logic [29:0] n_ns;
        longint      s, sn;
        logic [31:0] stg_ns, stg_sec;
        cw  = reg_wr && reg_addr == 2'd0;
        cmd = cw ? reg_wdata : 16'h0;
        stg_ns  = {m_stage[1], m_stage[0]};
        stg_sec = {m_stage[3], m_stage[2]};
        sum = 33'(m_acc) + 33'({m_hi, m_lo});
        inc = 8;
        if (sum[32]) inc = m_dir ? 9 : 7;
        n_sec = m_sec;
        n_ns  = m_ns;
        if (cmd[2]) begin
            n_sec = stg_sec;
            n_ns  = (stg_ns >= 32'd1000000000) ? 30'd0 : stg_ns[29:0];
        end else if (cmd[3]) begin
            sn = longint'($signed(stg_ns));
            if (sn >= 1000000000 || sn <= -1000000000) sn = 0;
            s = longint'(m_ns) + sn;
            n_sec = m_sec + stg_sec;
            if (s < 0) begin
                s = s + 1000000000;
                n_sec = n_sec - 1;
            end else if (s >= 1000000000) begin
                s = s - 1000000000;
                n_sec = n_sec + 1;
            end
            n_ns = 30'(s);
        end else if (m_run) begin
            s = longint'(m_ns) + inc;
            if (s >= 1000000000) begin
                s = s - 1000000000;
                n_sec = m_sec + 1;
            end
            n_ns = 30'(s);
        end
        @(posedge clk);
        if (cmd[4]) begin
            m_shadow[0] = m_ns[15:0];
            m_shadow[1] = {2'b00, m_ns[29:16]};
            m_shadow[2] = m_sec[15:0];
            m_shadow[3] = m_sec[31:16];
        end
        if (m_run) m_acc = sum[31:0];
        if (cw) m_ptr = 2'd0;
        if (reg_wr && reg_addr == 2'd1) begin
            m_stage[m_ptr] = reg_wdata;
            m_ptr = m_ptr + 1;
        end else if (reg_rd && reg_addr == 2'd1) begin
            m_ptr = m_ptr + 1;
        end
        if (reg_wr && reg_addr == 2'd2) begin
            m_dir = reg_wdata[15];
            m_hi  = reg_wdata[9:0];
        end
        if (reg_wr && reg_addr == 2'd3) m_lo = reg_wdata;
        if (cmd[0])      m_run = 1'b1;
        else if (cmd[1]) m_run = 1'b0;
        m_sec = n_sec;
        m_ns  = n_ns;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_rd = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] v);
        reg_addr  = a;
        reg_wdata = v;
        reg_wr    = 1'b1;
        tick();
    endtask

    task automatic rd(string tag);
        reg_addr = 2'd1;
        reg_rd   = 1'b1;
        #1;
        check(tag, 64'(reg_rdata), 64'(m_shadow[m_ptr]));
        tick();
    endtask

    task automatic stage(logic [31:0] s, logic [31:0] n);
        wr(2'd1, n[15:0]);
        wr(2'd1, n[31:16]);
        wr(2'd1, s[15:0]);
        wr(2'd1, s[31:16]);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4321));
        m_sec = 0; m_ns = 0; m_acc = 0; m_run = 0; m_dir = 0;
        m_hi = 0; m_lo = 0; m_ptr = 0;
        for (int i = 0; i < 4; i++) begin
            m_stage[i] = 0;
            m_shadow[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_time("R1 reset");
        reg_addr = 2'd1;
        #1;
        check("R1 rdata", 64'(reg_rdata), 64'h0);

        // R2 load then R6 start and R7 wrap
        stage(32'd5, 32'd999999980);
        wr(2'd0, 16'h0004);
        check_time("R2 load");
        idle(2);
        check_time("R6 halted hold");
        wr(2'd0, 16'h0001);
        idle(4);
        check_time("R7 wrap carry");
        // R2 out-of-range ns
        stage(32'd9, 32'd1000000000);
        wr(2'd0, 16'h0004);
        check_time("R2 ns clamp");
        // R3 negative step with borrow
        stage(32'd0, 32'hFFFFFF9C);
        wr(2'd0, 16'h0008);
        check_time("R3 negative step borrow");
        stage(32'hFFFFFFFE, 32'd999999999);
        wr(2'd0, 16'h0008);
        check_time("R3 step carry");
        // R5 partial sequence then command clears pointer
        wr(2'd1, 16'hAAAA);
        wr(2'd1, 16'hBBBB);
        wr(2'd0, 16'h0000);
        stage(32'h12345678, 32'd123456789);
        wr(2'd0, 16'h0004);
        check_time("R5 pointer cleared");
        // R4 latch and ordered readback, R5 partial read
        wr(2'd0, 16'h0010);
        rd("R4 word0");
        rd("R4 word1");
        wr(2'd0, 16'h0000);
        rd("R5 read restart word0");
        rd("R4 word1b");
        rd("R4 word2");
        rd("R4 word3");
        // R8 trim both directions
        wr(2'd2, 16'h83FF);
        wr(2'd3, 16'hFFFF);
        idle(200);
        check_time("R8 trim fast");
        wr(2'd2, 16'h03FF);
        idle(200);
        check_time("R8 trim slow");
        // R6 halt
        wr(2'd0, 16'h0002);
        idle(5);
        check_time("R6 halt");
        wr(2'd0, 16'h0003);
        idle(3);
        check_time("R6 run priority");

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 12;
            case (r)
                0, 1, 2: wr(2'd1, 16'($urandom));
                3:       wr(2'd0, 16'($urandom) & 16'h001F);
                4, 5:    rd("R4 random read");
                6:       wr(2'd2, 16'($urandom) & 16'h83FF);
                7:       wr(2'd3, 16'($urandom));
                8:       wr(2'd0, ($urandom % 2) ? 16'h0019 : 16'h0009);
                default: tick();
            endcase
            check_time("R3 R7 R8 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule